// File: doc/BRIEF.md
# Byte-Wide Configuration Loader Host

This block streams a configuration image into a target device through a byte-wide slave parallel port. Bytes enter on a valid/ready stream. The block presents each byte on an 8-bit bus and clocks it into the target with a configuration clock that it generates. The target samples the bus, its chip select and its write/read direction line on every rising edge of that clock.

All setup, hold and pulse-width margins come from counting cycles of the system clock. The phase lengths are parameters: `LEAD_CYC` for the control-line lead, `LOW_CYC` for the low phase and data setup, and `HIGH_CYC` for the high phase.

A pulse on `start_i` begins an image. The block drives the direction line low (write) first, then chip select, then the bus, and only then the first rising edge. The stream rules are as follows:
- A byte is taken in a cycle where both `s_valid_i` and `s_ready_o` are high.
- `s_ready_o` goes high only while the configuration clock is parked low, waiting for the next byte.
- The producer may hold `s_valid_i` low for any length of time. The configuration clock then stays low and chip select stays asserted, which pauses the target.
- A byte accepted with `s_last_i` high is the last byte of the image.

There are two ways to leave a transfer:
- **Normal end.** The block releases the bus, raises chip select and then raises the direction line. It then sets `done_o`, which stays high until the next start.
- **Abort (`abort_i`).** The block releases the bus and raises the direction line while chip select is still low, which tells the target to abort. It then returns to idle with `done_o` low.

Top module: `cfg_loader_host`

## Requirements
- R1: Every accepted byte appears on `bus_o` at exactly one rising edge of `cfg_clk_o`, in acceptance order, with none lost, repeated or invented.
- R2: After `start_i`, `dir_n_o` falls first, then `sel_n_o`, then `bus_oe_o` rises, then `cfg_clk_o` rises, each in a later cycle. At every rising edge, `sel_n_o`=0, `dir_n_o`=0 and `bus_oe_o`=1.
- R3: `bus_o` is unchanged for at least `LOW_CYC` cycles before each rising edge, throughout the high phase, and in the cycle in which `cfg_clk_o` falls.
- R4: Each high phase of `cfg_clk_o` lasts exactly `HIGH_CYC` cycles. Each low phase before a rising edge lasts at least `LOW_CYC` cycles.
- R5: While `s_valid_i` is low during a transfer, `cfg_clk_o` stays low, `sel_n_o` stays 0 and `busy_o` stays 1. The cycle after any cycle with `s_ready_o`=1 has `cfg_clk_o`=0.
- R6: `bus_oe_o` is never 1 while `dir_n_o` is 1. `bus_oe_o` is already 0 in the cycle before `dir_n_o` rises.
- R7: After the high phase of the last byte, the block releases the bus and sets `sel_n_o` to 1, with `dir_n_o` still 0. It then sets `dir_n_o` to 1, raises `done_o` and lowers `busy_o`. `done_o` holds until the next `start_i`.
- R8: Out of reset and in idle: `sel_n_o`=1, `dir_n_o`=1, `bus_oe_o`=0, `cfg_clk_o`=0, `busy_o`=0, `done_o`=0 (until a first image completes), and `s_ready_o`=0.
- R9: `abort_i` high while busy is acted on in every state except the final chip-select release. In that cycle and afterwards, `s_ready_o` is 0 and no byte is taken. A high phase already under way completes its full `HIGH_CYC` cycles. The block then releases the bus, raises `dir_n_o` while `sel_n_o` is 0, raises `sel_n_o`, and returns to idle with `done_o`=0.
- R10: `start_i` while busy has no effect on the transfer, and `abort_i` while idle has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new image (ignored while busy) |
| abort_i | input | 1 | Request an abort of the transfer |
| s_valid_i | input | 1 | Stream byte is valid |
| s_data_i | input | DW | Stream byte |
| s_last_i | input | 1 | Marks the final byte of the image |
| s_ready_o | output | 1 | Block takes the byte this cycle if valid |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| sel_n_o | output | 1 | Active-low chip select |
| dir_n_o | output | 1 | Direction: 0 write, 1 read / release |
| bus_o | output | DW | Data bus value |
| bus_oe_o | output | 1 | Data bus driver enable |
| busy_o | output | 1 | A transfer or exit sequence is in progress |
| done_o | output | 1 | Last image completed normally |

## Verification
Two situations can land in the same cycle.

**Abort meets a handshake.** The bench holds a byte valid, waits until `s_ready_o` is high, and then raises `abort_i` in that same cycle. It expects `s_ready_o` to drop at once. The scoreboard then fails the run if that byte ever reaches a rising edge.

**Abort meets the end of a high phase.** The bench raises `abort_i` while `cfg_clk_o` is high. It judges that the high phase still lasts `HIGH_CYC` cycles and that the byte in flight is delivered. It also checks that `dir_n_o` rises while `sel_n_o` is still low.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_LEAD,
    ST_SEL_LEAD,
    ST_WAIT,
    ST_SETUP,
    ST_HIGH,
    ST_FIN_LOW,
    ST_FIN_SEL,
    ST_ABT_REL,
    ST_ABT_DIR
  } cfgl_state_e;

  typedef struct packed {
    logic cclk;
    logic sel_n;
    logic dir_n;
    logic oe;
  } cfgl_ctl_t;

  localparam cfgl_ctl_t CTL_IDLE = '{cclk: 1'b0, sel_n: 1'b1, dir_n: 1'b1, oe: 1'b0};

  // Pin levels for each sequencer state; drv says a byte already sits on the bus.
  function automatic cfgl_ctl_t cfgl_decode(input cfgl_state_e st, input logic drv);
    cfgl_ctl_t c;
    c = CTL_IDLE;
    case (st)
      ST_DIR_LEAD: begin c.dir_n = 1'b0; end
      ST_SEL_LEAD: begin c.dir_n = 1'b0; c.sel_n = 1'b0; end
      ST_WAIT:     begin c.dir_n = 1'b0; c.sel_n = 1'b0; c.oe = drv; end
      ST_SETUP,
      ST_FIN_LOW:  begin c.dir_n = 1'b0; c.sel_n = 1'b0; c.oe = 1'b1; end
      ST_HIGH:     begin c.dir_n = 1'b0; c.sel_n = 1'b0; c.oe = 1'b1; c.cclk = 1'b1; end
      ST_FIN_SEL:  begin c.dir_n = 1'b0; end
      ST_ABT_REL:  begin c.dir_n = 1'b0; c.sel_n = 1'b0; end
      ST_ABT_DIR:  begin c.sel_n = 1'b0; end
      default:     c = CTL_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cfgl_phase_timer.sv
module cfgl_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             tc
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign tc = (cnt_q == '0);
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
  import cfgl_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LEAD_CYC = 2,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             s_valid_i,
  input  logic [DW-1:0]    s_data_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  input  logic             tmr_tc,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             busy_o,
  output logic             done_o,
  output cfgl_ctl_t        ctl_o,
  output logic [DW-1:0]    data_o
);
  cfgl_state_e      state_q, state_d;
  logic [DW-1:0]    data_q;
  logic             last_q, drv_q, pend_q, done_q;
  logic             accept;
  int unsigned      len_d;

  assign s_ready_o = (state_q == ST_WAIT) && !abort_i && !pend_q;
  assign accept    = s_ready_o && s_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_DIR_LEAD;
      ST_DIR_LEAD: if (abort_i) state_d = ST_ABT_REL;
                   else if (tmr_tc) state_d = ST_SEL_LEAD;
      ST_SEL_LEAD: if (abort_i) state_d = ST_ABT_REL;
                   else if (tmr_tc) state_d = ST_WAIT;
      ST_WAIT:     if (abort_i) state_d = ST_ABT_REL;
                   else if (accept) state_d = ST_SETUP;
      ST_SETUP:    if (abort_i) state_d = ST_ABT_REL;
                   else if (tmr_tc) state_d = ST_HIGH;
      ST_HIGH:     if (tmr_tc) begin
                     if (abort_i || pend_q) state_d = ST_ABT_REL;
                     else if (last_q)       state_d = ST_FIN_LOW;
                     else                   state_d = ST_WAIT;
                   end
      ST_FIN_LOW:  if (abort_i) state_d = ST_ABT_REL;
                   else if (tmr_tc) state_d = ST_FIN_SEL;
      ST_FIN_SEL:  if (tmr_tc) state_d = ST_IDLE;
      ST_ABT_REL:  if (tmr_tc) state_d = ST_ABT_DIR;
      ST_ABT_DIR:  if (tmr_tc) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_DIR_LEAD, ST_SEL_LEAD, ST_FIN_SEL,
      ST_ABT_REL, ST_ABT_DIR:  len_d = LEAD_CYC;
      ST_SETUP, ST_FIN_LOW:    len_d = LOW_CYC;
      ST_HIGH:                 len_d = HIGH_CYC;
      default:                 len_d = 1;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = CNT_W'(len_d - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      last_q  <= 1'b0;
      drv_q   <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        data_q <= s_data_i;
        last_q <= s_last_i;
        drv_q  <= 1'b1;
      end
      if (state_q == ST_HIGH && abort_i) pend_q <= 1'b1;
      if (state_d == ST_IDLE) begin
        pend_q <= 1'b0;
        drv_q  <= 1'b0;
        last_q <= 1'b0;
      end
      if (state_q == ST_IDLE && start_i)             done_q <= 1'b0;
      else if (state_q == ST_FIN_SEL && tmr_tc)      done_q <= 1'b1;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign ctl_o  = cfgl_decode(state_q, drv_q);
  assign data_o = data_q;
endmodule

// File: rtl/cfgl_pin_stage.sv
module cfgl_pin_stage
  import cfgl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfgl_ctl_t     ctl_i,
  input  logic [DW-1:0] data_i,
  output cfgl_ctl_t     ctl_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_o  <= CTL_IDLE;
      data_o <= '0;
    end else begin
      ctl_o  <= ctl_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/cfg_loader_host.sv
module cfg_loader_host
  import cfgl_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LEAD_CYC = 2,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          s_valid_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic          cfg_clk_o,
  output logic          sel_n_o,
  output logic          dir_n_o,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int MAX_LH = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_PH = (LEAD_CYC > MAX_LH) ? LEAD_CYC : MAX_LH;
  localparam int CNT_W  = (MAX_PH < 2) ? 1 : $clog2(MAX_PH);

  logic             tmr_load, tmr_tc;
  logic [CNT_W-1:0] tmr_val;
  cfgl_ctl_t        ctl_d, ctl_q;
  logic [DW-1:0]    data_d;

  cfgl_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .tc(tmr_tc)
  );

  cfgl_seq #(
    .DW(DW), .LEAD_CYC(LEAD_CYC), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
    .s_ready_o(s_ready_o), .tmr_tc(tmr_tc), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .busy_o(busy_o), .done_o(done_o), .ctl_o(ctl_d), .data_o(data_d)
  );

  cfgl_pin_stage #(.DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_d), .data_i(data_d),
    .ctl_o(ctl_q), .data_o(bus_o)
  );

  assign cfg_clk_o = ctl_q.cclk;
  assign sel_n_o   = ctl_q.sel_n;
  assign dir_n_o   = ctl_q.dir_n;
  assign bus_oe_o  = ctl_q.oe;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
  parameter int DW       = 8,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort_i,
  input logic          s_ready_o,
  input logic          cfg_clk_o,
  input logic          sel_n_o,
  input logic          dir_n_o,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic          busy_o,
  input logic          done_o
);
  logic [15:0] hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= cfg_clk_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= cfg_clk_o ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
    end
  end

  AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk_o) |-> (!sel_n_o && !dir_n_o && bus_oe_o)); // R2
  AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_o && $past(cfg_clk_o)) |-> $stable(bus_o)); // R3
  AST_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_clk_o) |-> $stable(bus_o)); // R3
  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_clk_o) |-> (hi_run == 16'(HIGH_CYC))); // R4
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk_o) |-> (lo_run >= 16'(LOW_CYC))); // R4
  AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |=> !cfg_clk_o); // R5
  AST_CLK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_o |-> !sel_n_o); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> !dir_n_o); // R6
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_n_o) |-> $past(!bus_oe_o)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && sel_n_o && !bus_oe_o)); // R7
  AST_ABORT_STOPS_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && busy_o) |=> !s_ready_o); // R9
endmodule

bind cfg_loader_host cfgl_checker #(.DW(DW), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .s_ready_o(s_ready_o),
  .cfg_clk_o(cfg_clk_o), .sel_n_o(sel_n_o), .dir_n_o(dir_n_o), .bus_o(bus_o),
  .bus_oe_o(bus_oe_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_cfg_loader_host.sv
module tb_cfg_loader_host;
  localparam int CLK_PERIOD = 10;
  localparam int LOWC  = 2;
  localparam int HIGHC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0, s_valid_i = 1'b0, s_last_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic s_ready_o, cfg_clk_o, sel_n_o, dir_n_o, bus_oe_o, busy_o, done_o;
  logic [7:0] bus_o;

  cfg_loader_host dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
    .s_ready_o(s_ready_o), .cfg_clk_o(cfg_clk_o), .sel_n_o(sel_n_o),
    .dir_n_o(dir_n_o), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  bit expect_abort = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard at every rising configuration edge.
  logic prev_cfg = 0, prev_sel = 1, prev_dir = 1, prev_oe = 0;
  logic [7:0] prev_bus = 0, rise_bus = 0;
  int hi_run = 0, lo_run = 0, st_run = 0;
  int t_dir = 0, t_sel = 0, t_oe = 0;
  bit order_pending = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      st_run = (bus_o == prev_bus) ? st_run + 1 : 0;
      if (cfg_clk_o && !prev_cfg) begin
        if (exp_q.size() == 0) chk(0, "R1", "edge with no byte pending", bus_o, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(bus_o == e, "R1", "byte at rising edge", bus_o, e);
        end
        chk(!sel_n_o && !dir_n_o && bus_oe_o, "R2", "pins at rising edge",
            {sel_n_o, dir_n_o, bus_oe_o}, 3'b001);
        chk(st_run >= LOWC, "R3", "data setup cycles", st_run, LOWC);
        chk(lo_run >= LOWC, "R4", "low phase cycles", lo_run, LOWC);
        rise_bus = bus_o;
        if (order_pending) begin
          chk(t_dir < t_sel && t_sel < t_oe && t_oe < cyc, "R2", "entry order",
              t_sel - t_dir, 1);
          order_pending = 0;
        end
      end
      if (!cfg_clk_o && prev_cfg) begin
        chk(hi_run == HIGHC, "R4", "high phase cycles", hi_run, HIGHC);
        chk(bus_o == rise_bus, "R3", "data held at falling edge", bus_o, rise_bus);
      end
      if (cfg_clk_o) begin hi_run++; lo_run = 0; end
      else begin lo_run++; hi_run = 0; end
      if (!dir_n_o && prev_dir) begin t_dir = cyc; order_pending = 1; end
      if (!sel_n_o && prev_sel) t_sel = cyc;
      if (bus_oe_o && !prev_oe) t_oe = cyc;
      if (dir_n_o && !prev_dir) begin
        chk(!bus_oe_o && !prev_oe, "R6", "bus released before direction rise",
            {prev_oe, bus_oe_o}, 0);
        if (expect_abort) chk(!sel_n_o, "R9", "select low at direction rise", sel_n_o, 0);
        else              chk(sel_n_o, "R7", "select high at direction rise", sel_n_o, 1);
      end
      if (bus_oe_o && dir_n_o) chk(0, "R6", "contention", 1, 0);
      prev_cfg = cfg_clk_o; prev_sel = sel_n_o; prev_dir = dir_n_o;
      prev_oe = bus_oe_o; prev_bus = bus_o;
    end
  end

  // Driver: pushes each byte into the scoreboard once its handshake is certain.
  task automatic send_byte(input logic [7:0] d, input logic l);
    s_valid_i = 1'b1; s_data_i = d; s_last_i = l;
    while (!s_ready_o) @(negedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_idle(input string req);
    chk(sel_n_o && dir_n_o && !bus_oe_o && !cfg_clk_o && !busy_o && !s_ready_o,
        req, "idle pins", {sel_n_o, dir_n_o, bus_oe_o, cfg_clk_o, busy_o, s_ready_o},
        6'b110000);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog run hung actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R8");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R8");
    chk(!done_o, "R8", "done after reset", done_o, 0);

    // Continuous image
    pulse_start();
    send_byte(8'hA5, 0); send_byte(8'h3C, 0); send_byte(8'h00, 0);
    send_byte(8'hFF, 0); send_byte(8'h5A, 1);
    wait_idle();
    chk(done_o, "R7", "done after last byte", done_o, 1);
    chk_idle("R8");
    chk(exp_q.size() == 0, "R1", "all bytes delivered", exp_q.size(), 0);

    // Image with a stall and a stray start
    pulse_start();
    chk(!done_o, "R7", "done cleared by start", done_o, 0);
    send_byte(8'h11, 0); send_byte(8'h22, 0);
    repeat (6) @(negedge clk);
    pulse_start(); // R10: ignored while busy
    repeat (6) @(negedge clk);
    chk(!cfg_clk_o && !sel_n_o && busy_o, "R5", "paused pins",
        {cfg_clk_o, sel_n_o, busy_o}, 3'b001);
    chk(exp_q.size() == 0, "R5", "no byte repeated in pause", exp_q.size(), 0);
    send_byte(8'h33, 0); send_byte(8'h44, 0); send_byte(8'h55, 1);
    wait_idle();
    chk(done_o && exp_q.size() == 0, "R10", "image unharmed by stray start",
        exp_q.size(), 0);

    // Abort meeting a handshake in the same cycle
    expect_abort = 1'b1;
    pulse_start();
    send_byte(8'h66, 0); send_byte(8'h67, 0);
    s_valid_i = 1'b1; s_data_i = 8'h77;
    while (!s_ready_o) @(negedge clk);
    abort_i = 1'b1;
    #1;
    chk(!s_ready_o, "R9", "ready drops with abort", s_ready_o, 0);
    @(negedge clk);
    abort_i = 1'b0; s_valid_i = 1'b0;
    wait_idle();
    chk(!done_o, "R9", "done stays low after abort", done_o, 1'b0);
    chk_idle("R9");
    chk(exp_q.size() == 0, "R9", "no byte lost or added", exp_q.size(), 0);

    // Abort during a high phase
    pulse_start();
    send_byte(8'h81, 0); send_byte(8'h82, 0);
    for (int i = 0; i < 50 && !cfg_clk_o; i++) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    wait_idle();
    chk(!done_o && exp_q.size() == 0, "R9", "high phase finished then aborted",
        exp_q.size(), 0);
    chk_idle("R9");
    expect_abort = 1'b0;

    // Abort while idle has no effect
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    repeat (2) @(negedge clk);
    chk_idle("R10");
    pulse_start();
    send_byte(8'hC3, 1);
    wait_idle();
    chk(done_o && exp_q.size() == 0, "R10", "image after idle abort", done_o, 1);

    finish_run();
  end
endmodule